// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable ratio N = B·P + A. A prescaler divides the input clock by either P or P+1. A swallow counter keeps the prescaler at P+1 for the first A prescaler cycles of each output period. A main counter, loaded with B, sets the length of the whole period in prescaler cycles. Over one period the prescaler completes A cycles of P+1 clocks and B−A cycles of P clocks, so the total is B·P + A input clocks. This lets the divider step in single input clocks even though the prescaler only has two division ratios.

The prescaler is modelled as an enable counter clocked by the input clock. It emits a one-clock tick each time it completes a cycle. The modulus choice P ∈ {8, 16, 32, 64} and the A and B values are sampled only when a period ends. A change made part-way through a period therefore takes effect at the next period. A flag reports whether the sampled setting lies outside the legal range.

Top module: `psd_divider`

## Requirements
- R1: With 3 ≤ B and A < B, consecutive `div_pulse` assertions are exactly B·P + A input clocks apart.
- R2: `pre_sel` selects the prescaler base modulus P = 8 << `pre_sel`: 0→8, 1→16, 2→32, 3→64. Every prescaler cycle lasts P clocks, or P+1 clocks while `mod_hi` is high.
- R3: `div_pulse` is high for exactly one input clock per period.
- R4: In each period, `mod_hi` is high for the first A prescaler cycles, which is A·(P+1) input clocks. It is low again before the period's last prescaler cycle completes.
- R5: New `pre_sel`, `b_val` and `a_val` values are sampled only at a period boundary. The period that is running when they change keeps its old length, and the next period uses the new setting.
- R6: `cfg_bad` is high when the sampled setting has A ≥ B or B < 3, and low otherwise. It changes only at a period boundary.
- R7: While `rst_n` is low, `div_pulse`, `mod_hi` and `cfg_bad` are low. After release, the first period starts from the current inputs and its pulse arrives within B·P + A + 3 clocks.
- R8: With A = 0, `mod_hi` stays low for the whole period and the pulses are B·P clocks apart.
- R9: The largest swallow count A = 63 gives the ratio B·P + 63 (for example 575 with P = 8 and B = 64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| pre_sel | input | 2 | Prescaler base modulus select, P = 8 << pre_sel |
| b_val | input | 13 | Main counter value B, legal range 3 to 8191 |
| a_val | input | 6 | Swallow count A, legal range 0 to 63, below B |
| div_pulse | output | 1 | One-clock pulse marking each completed period |
| mod_hi | output | 1 | Modulus control: high while the prescaler divides by P+1 |
| cfg_bad | output | 1 | High when the sampled setting is out of range |

## Verification
The checker watches the cycle-level rules on every clock. It checks that each prescaler cycle lasts P or P+1 clocks as `mod_hi` dictates, that the output pulse is one clock wide, that swallowing is finished whenever a valid period ends, and that `mod_hi` rises and `cfg_bad` changes only just after a period boundary. The total period length B·P + A, and the count of `mod_hi` clocks per period, are properties of a whole period. The bench alone shows these by counting clocks between pulses for several modulus choices and swallow counts, including A = 0 and A = 63. The bench scenarios are also the only check that a setting changed mid-period leaves the running period untouched.

// File: rtl/psd_pkg.sv
package psd_pkg;

   // Which of the two prescaler ratios is in force
   typedef enum logic {
      MOD_BASE = 1'b0,
      MOD_PLUS = 1'b1
   } psd_mod_e;

   // Width needed for a prescaler counter reaching the largest P+1
   function automatic int unsigned pc_width(int unsigned log2_min, int unsigned sel_w);
      return log2_min + (1 << sel_w);
   endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
   import psd_pkg::*;
#(
   parameter int unsigned SEL_W      = 2,
   parameter int unsigned P_LOG2_MIN = 3
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             swallow,
   input  logic [SEL_W-1:0] sel_act,
   output logic             pre_tick
);
   localparam int unsigned PC_W = pc_width(P_LOG2_MIN, SEL_W);

   logic [PC_W-1:0] pcnt;
   logic [PC_W-1:0] base_mod;
   logic [PC_W-1:0] term;
   psd_mod_e        mode;

   assign mode     = swallow ? MOD_PLUS : MOD_BASE;
   assign base_mod = PC_W'(1) << (P_LOG2_MIN + 32'(sel_act));
   assign term     = (mode == MOD_PLUS) ? base_mod : (base_mod - PC_W'(1));
   assign pre_tick = (pcnt == term);

   always_ff @(posedge clk_in) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (clr || pre_tick) begin
         pcnt <= '0;
      end else begin
         pcnt <= pcnt + PC_W'(1);
      end
   end
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow #(
   parameter int unsigned SEL_W = 2,
   parameter int unsigned A_W   = 6,
   parameter int unsigned B_W   = 13
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             pre_tick,
   input  logic [SEL_W-1:0] sel_in,
   input  logic [B_W-1:0]   b_in,
   input  logic [A_W-1:0]   a_in,
   output logic             swallow,
   output logic [SEL_W-1:0] sel_act,
   output logic             end_evt,
   output logic             load_evt,
   output logic             cfg_bad
);
   localparam logic [B_W-1:0] B_MIN = B_W'(3);
   localparam logic [B_W-1:0] B_ONE = B_W'(1);

   logic           start_q;
   logic [A_W-1:0] a_left;
   logic [B_W-1:0] b_left;

   assign swallow  = (a_left != '0);
   assign end_evt  = pre_tick && (b_left == B_ONE);
   assign load_evt = start_q || end_evt;

   always_ff @(posedge clk_in) begin
      if (!rst_n) begin
         start_q <= 1'b1;
         a_left  <= '0;
         b_left  <= '0;
         sel_act <= '0;
         cfg_bad <= 1'b0;
      end else if (load_evt) begin
         start_q <= 1'b0;
         a_left  <= a_in;
         b_left  <= b_in;
         sel_act <= sel_in;
         cfg_bad <= (B_W'(a_in) >= b_in) || (b_in < B_MIN);
      end else if (pre_tick) begin
         b_left <= b_left - B_ONE;
         if (swallow) begin
            a_left <= a_left - A_W'(1);
         end
      end
   end
endmodule

// File: rtl/psd_divider.sv
module psd_divider #(
   parameter int unsigned SEL_W      = 2,
   parameter int unsigned A_W        = 6,
   parameter int unsigned B_W        = 13,
   parameter int unsigned P_LOG2_MIN = 3,
   parameter bit          REG_OUT    = 1'b1
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] pre_sel,
   input  logic [B_W-1:0]   b_val,
   input  logic [A_W-1:0]   a_val,
   output logic             div_pulse,
   output logic             mod_hi,
   output logic             cfg_bad
);
   generate
      if (A_W >= B_W) begin : g_chk_aw
         $error("psd_divider: swallow width must be below main counter width");
      end
      if (P_LOG2_MIN < 1) begin : g_chk_pmin
         $error("psd_divider: smallest modulus must be at least 2");
      end
      if (SEL_W < 1 || SEL_W > 3) begin : g_chk_sel
         $error("psd_divider: modulus select width out of range");
      end
   endgenerate

   logic             pre_tick;
   logic             load_evt;
   logic             end_evt;
   logic             swallow;
   logic [SEL_W-1:0] sel_act;

   psd_prescaler #(
      .SEL_W      (SEL_W),
      .P_LOG2_MIN (P_LOG2_MIN)
   ) u_pre (
      .clk_in   (clk_in),
      .rst_n    (rst_n),
      .clr      (load_evt),
      .swallow  (swallow),
      .sel_act  (sel_act),
      .pre_tick (pre_tick)
   );

   psd_swallow #(
      .SEL_W (SEL_W),
      .A_W   (A_W),
      .B_W   (B_W)
   ) u_sw (
      .clk_in   (clk_in),
      .rst_n    (rst_n),
      .pre_tick (pre_tick),
      .sel_in   (pre_sel),
      .b_in     (b_val),
      .a_in     (a_val),
      .swallow  (swallow),
      .sel_act  (sel_act),
      .end_evt  (end_evt),
      .load_evt (load_evt),
      .cfg_bad  (cfg_bad)
   );

   assign mod_hi = swallow;

   generate
      if (REG_OUT) begin : g_out_reg
         logic pulse_q;
         always_ff @(posedge clk_in) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= end_evt;
         end
         assign div_pulse = pulse_q;
      end else begin : g_out_comb
         assign div_pulse = end_evt && rst_n;
      end
   endgenerate
endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk
   import psd_pkg::*;
#(
   parameter int unsigned SEL_W      = 2,
   parameter int unsigned P_LOG2_MIN = 3
) (
   input logic             clk_in,
   input logic             rst_n,
   input logic             div_pulse,
   input logic             mod_hi,
   input logic             cfg_bad,
   input logic             pre_tick,
   input logic             load_evt,
   input logic             end_evt,
   input logic [SEL_W-1:0] sel_act
);
   localparam int unsigned PC_W = pc_width(P_LOG2_MIN, SEL_W) + 1;

   logic [PC_W-1:0] gap;
   logic [PC_W-1:0] want;

   assign want = (PC_W'(1) << (P_LOG2_MIN + 32'(sel_act))) + PC_W'(mod_hi);

   always_ff @(posedge clk_in) begin
      if (!rst_n)                     gap <= '0;
      else if (pre_tick || load_evt)  gap <= '0;
      else                            gap <= gap + PC_W'(1);
   end

   // R2: each prescaler cycle spans P or P+1 clocks
   p_prescale_len_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
      pre_tick |-> (gap + PC_W'(1) == want));

   // R3: output pulse lasts one clock
   p_pulse_single_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   // R4: a valid period ends only after swallowing has finished
   p_swallow_done_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
      (end_evt && !cfg_bad) |-> !mod_hi);

   // R5: swallowing can begin only right after a period boundary
   p_mod_rise_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
      $rose(mod_hi) |-> $past(load_evt));

   // R6: range flag moves only at a period boundary
   p_cfg_change_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
      $changed(cfg_bad) |-> $past(load_evt));
endmodule

bind psd_divider psd_divider_chk #(
   .SEL_W      (SEL_W),
   .P_LOG2_MIN (P_LOG2_MIN)
) u_chk (
   .clk_in    (clk_in),
   .rst_n     (rst_n),
   .div_pulse (div_pulse),
   .mod_hi    (mod_hi),
   .cfg_bad   (cfg_bad),
   .pre_tick  (pre_tick),
   .load_evt  (load_evt),
   .end_evt   (end_evt),
   .sel_act   (sel_act)
);

// File: tb/psd_divider_test.sv
module psd_divider_test;
   logic        clk_in = 1'b0;
   logic        rst_n;
   logic [1:0]  pre_sel;
   logic [12:0] b_val;
   logic [5:0]  a_val;
   logic        div_pulse;
   logic        mod_hi;
   logic        cfg_bad;

   int total = 0;
   int bad   = 0;

   always #4 clk_in = ~clk_in;

   psd_divider uut (
      .clk_in    (clk_in),
      .rst_n     (rst_n),
      .pre_sel   (pre_sel),
      .b_val     (b_val),
      .a_val     (a_val),
      .div_pulse (div_pulse),
      .mod_hi    (mod_hi),
      .cfg_bad   (cfg_bad)
   );

   // {sel, B, A}
   localparam int NV = 7;
   localparam logic [20:0] VEC [NV] = '{
      {2'd0, 13'd3,  6'd0},
      {2'd0, 13'd5,  6'd2},
      {2'd1, 13'd4,  6'd3},
      {2'd2, 13'd10, 6'd7},
      {2'd3, 13'd20, 6'd19},
      {2'd0, 13'd64, 6'd63},
      {2'd3, 13'd3,  6'd2}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input int s, input int b, input int a);
      pre_sel = 2'(s);
      b_val   = 13'(b);
      a_val   = 6'(a);
   endtask

   task automatic wait_pulse();
      @(negedge clk_in);
      while (!div_pulse) @(negedge clk_in);
   endtask

   task automatic count_interval(output int n, output int hi);
      n  = 0;
      hi = 0;
      do begin
         @(negedge clk_in);
         n++;
         if (mod_hi) hi++;
      end while (!div_pulse);
   endtask

   initial begin
      repeat (100000) @(posedge clk_in);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n, hi, c;
      rst_n = 1'b0;
      set_cfg(0, 3, 0);
      repeat (4) @(negedge clk_in);
      check(div_pulse == 1'b0, "R7 reset pulse", int'(div_pulse), 0);
      check(mod_hi == 1'b0,    "R7 reset mod_hi", int'(mod_hi), 0);
      check(cfg_bad == 1'b0,   "R7 reset cfg_bad", int'(cfg_bad), 0);
      rst_n = 1'b1;
      c = 0;
      do begin
         @(negedge clk_in);
         c++;
      end while (!div_pulse && c < 200);
      check(c <= 27, "R7 first pulse delay", c, 27);

      // table walk: R1, R2, R4, R8, R9
      for (int i = 0; i < NV; i++) begin
         int s, b, a, p, exp_n, exp_hi;
         s = int'(VEC[i][20:19]);
         b = int'(VEC[i][18:6]);
         a = int'(VEC[i][5:0]);
         p = 8 << s;
         exp_n  = b * p + a;
         exp_hi = a * (p + 1);
         set_cfg(s, b, a);
         wait_pulse();
         count_interval(n, hi);
         if (a == 0)       check(n == exp_n, "R8 ratio with no swallow", n, exp_n);
         else if (a == 63) check(n == exp_n, "R9 ratio with full swallow", n, exp_n);
         else              check(n == exp_n, "R1 R2 ratio", n, exp_n);
         check(hi == exp_hi, "R4 mod_hi clocks", hi, exp_hi);
         check(cfg_bad == 1'b0, "R6 valid setting flag", int'(cfg_bad), 0);
         @(negedge clk_in);
         check(div_pulse == 1'b0, "R3 pulse width", int'(div_pulse), 0);
      end

      // R5: mid-period change waits for the boundary
      set_cfg(0, 5, 2);
      wait_pulse();
      wait_pulse();
      c = 0;
      repeat (5) begin
         @(negedge clk_in);
         c++;
      end
      set_cfg(1, 4, 3);
      do begin
         @(negedge clk_in);
         c++;
      end while (!div_pulse);
      check(c == 42, "R5 running period kept", c, 42);
      count_interval(n, hi);
      check(n == 67, "R5 next period new", n, 67);

      // R6: range flag
      set_cfg(0, 5, 5);
      wait_pulse();
      @(negedge clk_in);
      check(cfg_bad == 1'b1, "R6 A equals B", int'(cfg_bad), 1);
      set_cfg(0, 2, 0);
      wait_pulse();
      @(negedge clk_in);
      check(cfg_bad == 1'b1, "R6 B below 3", int'(cfg_bad), 1);
      set_cfg(0, 6, 5);
      wait_pulse();
      @(negedge clk_in);
      check(cfg_bad == 1'b0, "R6 valid again", int'(cfg_bad), 0);
      wait_pulse();
      repeat (3) @(negedge clk_in);
      set_cfg(0, 4, 7);
      repeat (10) @(negedge clk_in);
      check(cfg_bad == 1'b0, "R6 no mid-period change", int'(cfg_bad), 0);
      wait_pulse();
      @(negedge clk_in);
      check(cfg_bad == 1'b1, "R6 A above B", int'(cfg_bad), 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule